// File: doc/BRIEF.md
# Programmable Bus Clock Divider

This block derives a bus clock from a primary clock. A 32-bit configuration register is written through a simple Wishbone-style slave port. A 4-bit field in the register selects the clock ratio, and the low byte of the register holds an unrelated global control byte that is brought out as a port. When the field's top bit is clear, the primary clock passes straight to the output. When the top bit is set, the output period is two plus the field's low three bits, in primary cycles, so every integer ratio from 2 to 9 is available.

A new ratio never cuts short an output period that is already running. The setting only moves into the divider when the current output period ends, so changing the ratio cannot produce a runt pulse. For odd ratios the high phase is the shorter one. Only the period is exact; the duty cycle is not held at 50%.

Top module: `busclk_divgen`

## Requirements
- R1: While reset (active high) is asserted, the configuration register clears to zero, so the global control byte reads 0x00 and the output is the undivided primary clock.
- R2: When cyc and stb are both high and ack is low, ack rises on the next clock edge. It stays high for exactly one cycle and is returned for every access, whatever its address.
- R3: A write to the configuration address changes only the byte lanes whose select bit is set. Lane k covers data bits [8k+7:8k], so sel=0001 updates only bits [7:0].
- R4: A write to any address other than the configuration address leaves the register unchanged, and it is still acknowledged.
- R5: A read of the configuration address returns the full register value on the data output during the ack cycle. Reads of other addresses return zero.
- R6: Ratio field values 0x0 through 0x7 (bits [11:8], top bit clear) give an output period equal to the primary period.
- R7: Ratio field value 0x8 gives an output period of exactly 2 primary periods.
- R8: Ratio field values 0x9 through 0xF give an output period of exactly 2 + bits[10:8] primary periods, from 3 up to 9.
- R9: With division on at ratio N, the output is high for floor(N/2) primary cycles and low for the remaining ceil(N/2) cycles of each period.
- R10: A ratio written during an output period leaves that period at its old length. The new ratio applies from the next period onward.
- R11: The global control byte output always equals bits [7:0] of the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary clock; also clocks the register port |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Access strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W (32) | Access address |
| wb_dat_i | input | DATA_W (32) | Write data |
| wb_sel_i | input | DATA_W/8 (4) | Byte-lane select |
| wb_dat_o | output | DATA_W (32) | Read data, valid while ack is high |
| wb_ack_o | output | 1 | One-cycle access acknowledge |
| glb_ctrl_o | output | GLB_W (8) | Global control byte from register bits [7:0] |
| bus_clk_o | output | 1 | Derived bus clock |

## Verification
The bench builds the block with its default widths: 32-bit address and data, a 4-bit ratio field at bit 8, and an 8-bit control byte. It moves the configuration address away from zero to 0x10, so that writes to address 0 become the foreign-address case. With a 4-bit field the full set of sixteen codes can be swept exhaustively: every pass-through code, and every ratio from 2 to 9, each with both odd and even high/low splits. A ratio change from /9 to /3 is timed edge by edge to show the period-boundary hand-over.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

   typedef enum logic {
      MODE_PASS = 1'b0,
      MODE_DIV  = 1'b1
   } busclk_mode_e;

   // Largest ratio a field of the given width can request: 2 + (2^(w-1) - 1)
   function automatic int max_ratio(input int ctrl_w);
      return (1 << (ctrl_w - 1)) + 1;
   endfunction

   // Counter width needed to hold the largest ratio value itself
   function automatic int ratio_cnt_w(input int ctrl_w);
      return $clog2(max_ratio(ctrl_w) + 1);
   endfunction

endpackage

// File: rtl/busclk_cfg_slave.sv
module busclk_cfg_slave #(
   parameter int          ADDR_W   = 32,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] CFG_ADDR = 32'h0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cyc,
   input  logic                  stb,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     adr,
   input  logic [DATA_W-1:0]     wdat,
   input  logic [DATA_W/8-1:0]   sel,
   output logic [DATA_W-1:0]     rdat,
   output logic                  ack,
   output logic [DATA_W-1:0]     cfg_q
);

   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("busclk_cfg_slave: DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("busclk_cfg_slave: ADDR_W must lie in 1..32");
      end
   endgenerate

   logic              ack_q;
   logic [DATA_W-1:0] rdat_q;
   logic              req_new;
   logic              hit;
   logic [7:0]        lane_q [LANES];

   assign req_new = cyc && stb && !ack_q;
   assign hit     = (adr == CFG_ADDR[ADDR_W-1:0]);

   generate
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         always_ff @(posedge clk) begin
            if (rst) begin
               lane_q[b] <= 8'h00;
            end else if (req_new && we && hit && sel[b]) begin
               lane_q[b] <= wdat[b*8 +: 8];
            end
         end
         assign cfg_q[b*8 +: 8] = lane_q[b];

         // R3
         lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (req_new && we && !sel[b]) |=> $stable(lane_q[b]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q  <= 1'b0;
         rdat_q <= '0;
      end else begin
         ack_q <= req_new;
         if (req_new && !we && hit) begin
            rdat_q <= cfg_q;
         end else begin
            rdat_q <= '0;
         end
      end
   end

   assign ack  = ack_q;
   assign rdat = rdat_q;

   // R2
   ack_single_chk: assert property (@(posedge clk) disable iff (rst)
      ack_q |=> !ack_q);

   // R2
   ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc && stb && !ack_q) |=> ack_q);

   // R4
   foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (req_new && we && !hit) |=> $stable(cfg_q));

endmodule

// File: rtl/busclk_ratio_dec.sv
module busclk_ratio_dec
   import busclk_pkg::*;
#(
   parameter int CTRL_W = 4,
   parameter int CNT_W  = ratio_cnt_w(CTRL_W)
) (
   input  logic [CTRL_W-1:0] code,
   output busclk_mode_e      mode,
   output logic [CNT_W-1:0]  ratio
);

   localparam int OFS_W = CTRL_W - 1;

   generate
      if (CNT_W < ratio_cnt_w(CTRL_W)) begin : g_bad_cnt
         $error("busclk_ratio_dec: CNT_W too narrow for the largest ratio");
      end
   endgenerate

   always_comb begin
      mode  = code[CTRL_W-1] ? MODE_DIV : MODE_PASS;
      ratio = CNT_W'(2) + CNT_W'(code[OFS_W-1:0]);
   end

endmodule

// File: rtl/busclk_divcore.sv
module busclk_divcore
   import busclk_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  busclk_mode_e      req_mode,
   input  logic [CNT_W-1:0]  req_ratio,
   output logic              clk_out
);

   busclk_mode_e     act_mode;
   logic [CNT_W-1:0] act_ratio;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] high_len;
   logic             period_end;
   logic             div_q;

   assign cnt_inc    = cnt + CNT_W'(1);
   assign last_cnt   = act_ratio - CNT_W'(1);
   assign high_len   = act_ratio >> 1;
   assign period_end = (act_mode == MODE_PASS) || (cnt == last_cnt);

   always_ff @(posedge clk) begin
      if (rst) begin
         act_mode  <= MODE_PASS;
         act_ratio <= CNT_W'(2);
         cnt       <= '0;
         div_q     <= 1'b0;
      end else if (period_end) begin
         act_mode  <= req_mode;
         act_ratio <= req_ratio;
         cnt       <= '0;
         div_q     <= (req_mode == MODE_DIV);
      end else begin
         cnt   <= cnt_inc;
         div_q <= (cnt_inc < high_len);
      end
   end

   assign clk_out = (act_mode == MODE_PASS) ? clk : div_q;

   // R10
   hold_mid_period_chk: assert property (@(posedge clk) disable iff (rst)
      (act_mode == MODE_DIV && cnt != last_cnt) |=>
         ($stable(act_ratio) && act_mode == MODE_DIV));

   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (act_mode == MODE_DIV) |-> (cnt < act_ratio && act_ratio >= CNT_W'(2)));

   // R9
   high_start_chk: assert property (@(posedge clk) disable iff (rst)
      (act_mode == MODE_DIV && cnt == '0) |-> div_q);

   // R9
   low_end_chk: assert property (@(posedge clk) disable iff (rst)
      (act_mode == MODE_DIV && cnt == last_cnt) |-> !div_q);

endmodule

// File: rtl/busclk_divgen.sv
module busclk_divgen
   import busclk_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] CFG_ADDR = 32'h0,
   parameter int          CTRL_LSB = 8,
   parameter int          CTRL_W   = 4,
   parameter int          GLB_W    = 8
) (
   input  logic                pri_clk,
   input  logic                rst,
   input  logic                wb_cyc_i,
   input  logic                wb_stb_i,
   input  logic                wb_we_i,
   input  logic [ADDR_W-1:0]   wb_adr_i,
   input  logic [DATA_W-1:0]   wb_dat_i,
   input  logic [DATA_W/8-1:0] wb_sel_i,
   output logic [DATA_W-1:0]   wb_dat_o,
   output logic                wb_ack_o,
   output logic [GLB_W-1:0]    glb_ctrl_o,
   output logic                bus_clk_o
);

   localparam int CNT_W = ratio_cnt_w(CTRL_W);

   generate
      if (CTRL_W < 2) begin : g_bad_ctrl
         $error("busclk_divgen: CTRL_W must be at least 2");
      end
      if (CTRL_LSB + CTRL_W > DATA_W) begin : g_bad_field
         $error("busclk_divgen: ratio field does not fit the register");
      end
      if (GLB_W > CTRL_LSB) begin : g_bad_glb
         $error("busclk_divgen: control byte overlaps the ratio field");
      end
   endgenerate

   logic [DATA_W-1:0] cfg_q;
   logic [CTRL_W-1:0] ratio_code;
   busclk_mode_e      req_mode;
   logic [CNT_W-1:0]  req_ratio;

   busclk_cfg_slave #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CFG_ADDR (CFG_ADDR)
   ) u_cfg (
      .clk   (pri_clk),
      .rst   (rst),
      .cyc   (wb_cyc_i),
      .stb   (wb_stb_i),
      .we    (wb_we_i),
      .adr   (wb_adr_i),
      .wdat  (wb_dat_i),
      .sel   (wb_sel_i),
      .rdat  (wb_dat_o),
      .ack   (wb_ack_o),
      .cfg_q (cfg_q)
   );

   assign ratio_code = cfg_q[CTRL_LSB +: CTRL_W];
   assign glb_ctrl_o = cfg_q[GLB_W-1:0];

   busclk_ratio_dec #(
      .CTRL_W (CTRL_W),
      .CNT_W  (CNT_W)
   ) u_dec (
      .code  (ratio_code),
      .mode  (req_mode),
      .ratio (req_ratio)
   );

   busclk_divcore #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk       (pri_clk),
      .rst       (rst),
      .req_mode  (req_mode),
      .req_ratio (req_ratio),
      .clk_out   (bus_clk_o)
   );

   // R1
   reset_pass_chk: assert property (@(posedge pri_clk)
      $past(rst) |-> (cfg_q == '0));

endmodule

// File: tb/busclk_divgen_test.sv
`timescale 1ns/1ps
module busclk_divgen_test;

   localparam logic [31:0] CFG_A = 32'h0000_0010;
   localparam int          TCLK  = 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 1'b0;
   logic        stb = 1'b0;
   logic        we  = 1'b0;
   logic [31:0] adr = '0;
   logic [31:0] wdat = '0;
   logic [3:0]  sel = '0;
   logic [31:0] rdat;
   logic        ack;
   logic [7:0]  glb;
   logic        bclk;

   int checks = 0;
   int bad    = 0;
   bit done   = 0;
   time t_wr_edge;

   typedef struct {
      int  kind;   // 0 = mean period over edges, 1 = high time
      int  edges;
      longint expv;
   } sb_item_t;

   sb_item_t sb_q[$];
   string    tag_q[$];
   time      rises[$];
   bit       rec_on = 0;

   always #(TCLK/2) clk = ~clk;

   busclk_divgen #(.CFG_ADDR(CFG_A)) uut (
      .pri_clk    (clk),
      .rst        (rst),
      .wb_cyc_i   (cyc),
      .wb_stb_i   (stb),
      .wb_we_i    (we),
      .wb_adr_i   (adr),
      .wb_dat_i   (wdat),
      .wb_sel_i   (sel),
      .wb_dat_o   (rdat),
      .wb_ack_o   (ack),
      .glb_ctrl_o (glb),
      .bus_clk_o  (bclk)
   );

   task automatic check(input string tag, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   always @(posedge bclk) if (rec_on) rises.push_back($time);

   // Scoreboard monitor: pops expected timing items and measures them
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         begin
            sb_item_t it;
            time t0;
            longint meas;
            it = sb_q[0];
            @(posedge bclk);
            t0 = $time;
            if (it.kind == 0) begin
               repeat (it.edges) @(posedge bclk);
               meas = longint'(($time - t0) / it.edges);
            end else begin
               @(negedge bclk);
               meas = longint'($time - t0);
            end
            check(tag_q[0], meas, it.expv);
            void'(sb_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   task automatic bus_xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] s, output logic [31:0] rd);
      int waits;
      @(negedge clk);
      cyc = 1; stb = 1; we = w; adr = a; wdat = d; sel = s;
      waits = 0;
      do begin
         @(negedge clk);
         waits++;
      end while (!ack && waits < 8);
      t_wr_edge = $time - TCLK/2;
      rd = rdat;
      check("R2 ack latency", waits, 1);
      cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0; sel = '0;
      @(negedge clk);
      check("R2 ack single cycle", ack, 0);
   endtask

   task automatic push_item(input int kind, input int edges, input longint expv, input string tag);
      sb_item_t it;
      it.kind = kind; it.edges = edges; it.expv = expv;
      sb_q.push_back(it);
      tag_q.push_back(tag);
   endtask

   // Program a ratio code and queue the expected period and high time
   task automatic try_code(input logic [3:0] code);
      logic [31:0] rd;
      int n;
      n = code[3] ? (2 + int'(code[2:0])) : 1;
      bus_xfer(1, CFG_A, {20'h0, code, 8'h5A}, 4'hF, rd);
      repeat (3) @(posedge bclk);
      // R6 R7 R8: mean period over 100 edges
      push_item(0, 100, longint'(n * TCLK), $sformatf("R6/R7/R8 period code=%0h", code));
      // R9: high phase floor(N/2) cycles (half a cycle in pass-through)
      push_item(1, 0, code[3] ? longint'((n / 2) * TCLK) : longint'(TCLK / 2),
                $sformatf("R9 high time code=%0h", code));
      wait (sb_q.size() == 0);
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1: state during reset
      check("R1 glb in reset", glb, 0);
      check("R1 ack in reset", ack, 0);
      @(negedge clk);
      rst = 0;
      bus_xfer(0, CFG_A, '0, 4'hF, rd);
      check("R1 register after reset", rd, 0);
      // R1: pass-through after reset
      push_item(0, 100, TCLK, "R1 pass-through period");
      wait (sb_q.size() == 0);

      // R5 and R11: full write and read back
      bus_xfer(1, CFG_A, 32'hA5C3_0E77, 4'hF, rd);
      bus_xfer(0, CFG_A, '0, 4'hF, rd);
      check("R5 read back", rd, 32'hA5C3_0E77);
      check("R11 glb byte", glb, 8'h77);
      // R5: read of a foreign address gives zero
      bus_xfer(0, 32'h0, '0, 4'hF, rd);
      check("R5 foreign read", rd, 0);

      // R3: only lane 0 written
      bus_xfer(1, CFG_A, 32'hFFFF_FFAB, 4'b0001, rd);
      bus_xfer(0, CFG_A, '0, 4'hF, rd);
      check("R3 lane 0 only", rd, 32'hA5C3_0EAB);
      // R3: lanes 1 and 3
      bus_xfer(1, CFG_A, 32'h1122_3344, 4'b1010, rd);
      bus_xfer(0, CFG_A, '0, 4'hF, rd);
      check("R3 lanes 1 and 3", rd, 32'h11C3_33AB);
      check("R11 glb unchanged", glb, 8'hAB);

      // R4: write to another address is acknowledged yet ignored
      bus_xfer(1, 32'h0, 32'h0000_0F00, 4'hF, rd);
      bus_xfer(0, CFG_A, '0, 4'hF, rd);
      check("R4 foreign write ignored", rd, 32'h11C3_33AB);

      // R6 R7 R8 R9: sweep of every code
      for (int c = 0; c < 16; c++) try_code(4'(c));

      // R10: change /9 -> /3 mid-period
      try_code(4'hF);
      rises.delete();
      rec_on = 1;
      repeat (13) @(negedge clk);
      bus_xfer(1, CFG_A, {20'h0, 4'h9, 8'h5A}, 4'hF, rd);
      repeat (4) @(posedge bclk);
      rec_on = 0;
      begin
         int k;
         k = -1;
         foreach (rises[i]) if (rises[i] <= t_wr_edge) k = i;
         if (k < 0 || k + 2 >= rises.size()) begin
            check("R10 edges recorded", 0, 1);
         end else begin
            check("R10 period holding write", longint'(rises[k+1] - rises[k]), 9 * TCLK);
            check("R10 next period new ratio", longint'(rises[k+2] - rises[k+1]), 3 * TCLK);
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(TCLK * 150000);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule